// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block sits between one processor and a shared broadcast bus in a small multiprocessor. It keeps a direct-mapped store of lines, each holding several words. Every processor write goes through to main memory and is broadcast on the bus as one word. Peer controllers watch that broadcast and patch the matching word in place when they hold the line. Several caches may hold the same line and write it at the same time, because no cache ever takes exclusive ownership.

The processor side uses a request/ready handshake. A request is taken in one cycle and `cpu_ready` pulses for one cycle when the request is done. A read miss asks for the bus and fetches the whole line, one word per beat. A write asks for the bus and holds its broadcast until `bus_grant` arrives. In the grant cycle, and only then, the memory write port fires. While `bus_req` stays high the grant holder keeps the bus, so no peer broadcast can arrive while a line fill is running. Broadcasts from peers arrive on the snoop inputs. Each one carries the sender's identity, so the controller can recognise its own traffic.

Top module: `wu_snoop_cache`

## Requirements
- R1: After reset, `cpu_ready`, `bus_req` and `mem_we` are low and every line is invalid, so the first read of any address goes to the bus as a line fetch.
- R2: On a read miss the block raises `bus_req` with `bus_rd`=1 and `bus_addr` set to the line base, which is the address with its two lowest bits cleared. After the grant cycle it takes four fill beats in offset order 0..3. It returns the requested word with `cpu_ready` high in the cycle after the final beat.
- R3: A read hit raises `cpu_ready` in the cycle after the request is taken and drives no bus request. `cpu_ready` is never high in two cycles in a row.
- R4: A write raises `bus_req` with `bus_rd`=0, `bus_src`=SELF_ID (default 1), and the write address and data. These values stay stable until `bus_gnt`. In the grant cycle `mem_we` is high with the same address and data. `cpu_ready` follows one cycle later.
- R5: A write to a line that is present updates the local word, and a later read returns the new value without using the bus.
- R6: A write to a line that is absent allocates nothing, so a later read of that address misses and fetches from memory.
- R7: A peer broadcast (`snp_src` not equal to SELF_ID) to a present line replaces only the addressed word. The other words of the line keep their values.
- R8: A peer broadcast to an absent line is ignored: no line is created, and a later read misses and returns the memory contents.
- R9: A broadcast that carries the controller's own identity on `snp_src` leaves the store unchanged.
- R10: When a peer broadcast and a processor request target the same set in the same cycle, the broadcast is applied first and the request is taken one cycle later. A read there returns the patched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready on reads |
| bus_req | output | 1 | Bus request, held until done |
| bus_rd | output | 1 | 1 = line fetch, 0 = word update broadcast |
| bus_addr | output | ADDR_W | Broadcast word address or fetch line base |
| bus_wdata | output | DATA_W | Broadcast word |
| bus_src | output | SRC_W | Identity of this controller |
| bus_gnt | input | 1 | Bus grant |
| snp_valid | input | 1 | Peer update broadcast present |
| snp_addr | input | ADDR_W | Snooped word address |
| snp_data | input | DATA_W | Snooped word |
| snp_src | input | SRC_W | Identity of the broadcaster |
| mem_we | output | 1 | Memory write strobe (grant cycle of a write) |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| fill_valid | input | 1 | Fill beat present |
| fill_data | input | DATA_W | Fill word |

## Verification
The bench first reads a word at a non-zero offset on a miss. A design that took fill beats out of order, or captured the wrong beat, would return a neighbouring word or a stale word. It writes a line that is absent and reads it back. A design that allocated on a write would hit, and the bus fetch would never appear. It sends peer broadcasts to a present line, to an absent line and with the controller's own identity. A wrong design would corrupt neighbouring words, create a line from nothing, or apply its own echo. Finally it lines up a broadcast and a read to the same set in one cycle. A design without snoop-first ordering would answer one cycle early with the old data.

// File: rtl/wu_cache_pkg.sv
package wu_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_BUS,
    ST_FILL_REQ,
    ST_FILL,
    ST_DONE
  } wu_state_e;
endpackage

// File: rtl/wu_line_store.sv
module wu_line_store #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned TAG_W  = 7,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor-side lookup
  input  logic [IDX_W-1:0]  c_idx,
  input  logic [OFF_W-1:0]  c_off,
  input  logic [TAG_W-1:0]  c_tag,
  output logic              c_hit,
  output logic [DATA_W-1:0] c_word,
  // snoop-side lookup
  input  logic [IDX_W-1:0]  s_idx,
  input  logic [TAG_W-1:0]  s_tag,
  output logic              s_hit,
  // local word write
  input  logic              lw_en,
  input  logic [IDX_W-1:0]  lw_idx,
  input  logic [OFF_W-1:0]  lw_off,
  input  logic [DATA_W-1:0] lw_data,
  // snooped word write
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [OFF_W-1:0]  sw_off,
  input  logic [DATA_W-1:0] sw_data,
  // fill beat write
  input  logic              fw_en,
  input  logic              fw_last,
  input  logic [IDX_W-1:0]  fw_idx,
  input  logic [OFF_W-1:0]  fw_off,
  input  logic [TAG_W-1:0]  fw_tag,
  input  logic [DATA_W-1:0] fw_data
);
  localparam int unsigned SETS  = 1 << IDX_W;
  localparam int unsigned WORDS = 1 << OFF_W;

  logic [SETS-1:0]                    vld_q;
  logic [TAG_W-1:0]                   tag_q  [SETS];
  logic [WORDS-1:0][DATA_W-1:0]       line_q [SETS];
  logic [WORDS-1:0]                   wen    [SETS];
  logic [WORDS-1:0][DATA_W-1:0]       wdat   [SETS];
  logic [SETS-1:0]                    c_match;
  logic [SETS-1:0]                    s_match;

  // per-set tag compare for both lookup ports
  for (genvar g = 0; g < SETS; g++) begin : g_cmp
    assign c_match[g] = vld_q[g] && (tag_q[g] == c_tag);
    assign s_match[g] = vld_q[g] && (tag_q[g] == s_tag);
  end

  assign c_hit  = c_match[c_idx];
  assign s_hit  = s_match[s_idx];
  assign c_word = line_q[c_idx][c_off];

  // word write decode: fill beats over local writes over snooped writes
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WORDS; w++) begin
        wen[s][w]  = 1'b0;
        wdat[s][w] = sw_data;
        if (sw_en && sw_idx == IDX_W'(s) && sw_off == OFF_W'(w)) begin
          wen[s][w]  = 1'b1;
          wdat[s][w] = sw_data;
        end
        if (lw_en && lw_idx == IDX_W'(s) && lw_off == OFF_W'(w)) begin
          wen[s][w]  = 1'b1;
          wdat[s][w] = lw_data;
        end
        if (fw_en && fw_idx == IDX_W'(s) && fw_off == OFF_W'(w)) begin
          wen[s][w]  = 1'b1;
          wdat[s][w] = fw_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (wen[s][w]) line_q[s][w] <= wdat[s][w];
      end
    end
  end

  // a line is invalid while its fill is running and valid after the last beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (fw_en && fw_idx == IDX_W'(s)) vld_q[s] <= fw_last;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      if (fw_en && fw_last && fw_idx == IDX_W'(s)) tag_q[s] <= fw_tag;
    end
  end

  // R8: a snooped write only ever lands in a valid line
  assert_snoop_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> vld_q[sw_idx]);

  // R7: an uncontested snooped write leaves its word holding the broadcast data
  assert_snoop_patch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !fw_en && !(lw_en && lw_idx == sw_idx && lw_off == sw_off))
    |=> line_q[$past(sw_idx)][$past(sw_off)] == $past(sw_data));

  // R2: the last fill beat leaves the line valid
  assert_fill_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_en && fw_last) |=> vld_q[$past(fw_idx)]);
endmodule

// File: rtl/wu_snoop_filter.sv
module wu_snoop_filter #(
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned SRC_W   = 2,
  parameter int unsigned SELF_ID = 1
) (
  input  logic             snp_valid,
  input  logic [SRC_W-1:0] snp_src,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             s_hit,
  input  logic             cpu_look,
  input  logic [IDX_W-1:0] cpu_idx,
  output logic             snp_wr,
  output logic             snp_conflict
);
  logic from_peer;

  assign from_peer    = snp_valid && (snp_src != SRC_W'(SELF_ID));
  assign snp_wr       = from_peer && s_hit;
  // any peer broadcast to the set the processor is looking at wins the cycle
  assign snp_conflict = from_peer && cpu_look && (snp_idx == cpu_idx);
endmodule

// File: rtl/wu_ctrl_fsm.sv
module wu_ctrl_fsm
  import wu_cache_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_hit,
  input  logic              conflict,
  input  logic              bus_gnt,
  input  logic              fill_valid,
  output wu_state_e         state,
  output logic              accept,
  output logic              grant_wr,
  output logic              fill_beat,
  output logic              fill_last,
  output logic [OFF_W-1:0]  beat,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);
  localparam int unsigned WORDS = 1 << OFF_W;

  wu_state_e        state_q, state_d;
  logic [OFF_W-1:0] beat_q, beat_d;
  logic             beat_en;

  assign state     = state_q;
  assign beat      = beat_q;
  assign accept    = (state_q == ST_IDLE) && cpu_req && !conflict;
  assign grant_wr  = (state_q == ST_WR_BUS) && bus_gnt;
  assign fill_beat = (state_q == ST_FILL) && fill_valid;
  assign fill_last = fill_beat && (beat_q == OFF_W'(WORDS - 1));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (cpu_we)       state_d = ST_WR_BUS;
          else if (cpu_hit) state_d = ST_DONE;
          else              state_d = ST_FILL_REQ;
        end
      end
      ST_WR_BUS:   if (bus_gnt)   state_d = ST_DONE;
      ST_FILL_REQ: if (bus_gnt)   state_d = ST_FILL;
      ST_FILL:     if (fill_last) state_d = ST_DONE;
      ST_DONE:                    state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    beat_en = accept || fill_beat;
    beat_d  = accept ? '0 : beat_q + OFF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      req_addr <= cpu_addr;
      req_data <= cpu_wdata;
    end
  end

  // R10: a same-set snoop holds the processor request back for this cycle
  assert_snoop_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cpu_req && conflict) |=> (state_q == ST_IDLE));

  // R3: completion lasts exactly one cycle
  assert_done_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/wu_snoop_cache.sv
module wu_snoop_cache
  import wu_cache_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned OFF_W   = 2,
  parameter int unsigned SRC_W   = 2,
  parameter int unsigned SELF_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [SRC_W-1:0]  bus_src,
  input  logic              bus_gnt,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  input  logic [SRC_W-1:0]  snp_src,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

  // reset: asserted asynchronously, released through two flops
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  wu_state_e         state;
  logic              accept, grant_wr, fill_beat, fill_last;
  logic [OFF_W-1:0]  beat;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic [ADDR_W-1:0] look_addr;
  logic              c_hit, s_hit, snp_wr, snp_conflict;
  logic [DATA_W-1:0] c_word;
  logic              rdata_en;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  assign look_addr = (state == ST_IDLE) ? cpu_addr : req_addr;

  wu_ctrl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_hit    (c_hit),
    .conflict   (snp_conflict),
    .bus_gnt    (bus_gnt),
    .fill_valid (fill_valid),
    .state      (state),
    .accept     (accept),
    .grant_wr   (grant_wr),
    .fill_beat  (fill_beat),
    .fill_last  (fill_last),
    .beat       (beat),
    .req_addr   (req_addr),
    .req_data   (req_data)
  );

  wu_snoop_filter #(.IDX_W(IDX_W), .SRC_W(SRC_W), .SELF_ID(SELF_ID)) u_snoop (
    .snp_valid    (snp_valid),
    .snp_src      (snp_src),
    .snp_idx      (snp_addr[OFF_W +: IDX_W]),
    .s_hit        (s_hit),
    .cpu_look     ((state == ST_IDLE) && cpu_req),
    .cpu_idx      (cpu_addr[OFF_W +: IDX_W]),
    .snp_wr       (snp_wr),
    .snp_conflict (snp_conflict)
  );

  wu_line_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .c_idx   (look_addr[OFF_W +: IDX_W]),
    .c_off   (look_addr[OFF_W-1:0]),
    .c_tag   (look_addr[ADDR_W-1 -: TAG_W]),
    .c_hit   (c_hit),
    .c_word  (c_word),
    .s_idx   (snp_addr[OFF_W +: IDX_W]),
    .s_tag   (snp_addr[ADDR_W-1 -: TAG_W]),
    .s_hit   (s_hit),
    .lw_en   (grant_wr && c_hit),
    .lw_idx  (req_addr[OFF_W +: IDX_W]),
    .lw_off  (req_addr[OFF_W-1:0]),
    .lw_data (req_data),
    .sw_en   (snp_wr),
    .sw_idx  (snp_addr[OFF_W +: IDX_W]),
    .sw_off  (snp_addr[OFF_W-1:0]),
    .sw_data (snp_data),
    .fw_en   (fill_beat),
    .fw_last (fill_last),
    .fw_idx  (req_addr[OFF_W +: IDX_W]),
    .fw_off  (beat),
    .fw_tag  (req_addr[ADDR_W-1 -: TAG_W]),
    .fw_data (fill_data)
  );

  // read data: captured on an accepted hit, or on the matching fill beat
  always_comb begin
    rdata_en = 1'b0;
    rdata_d  = fill_data;
    if (accept && !cpu_we && c_hit) begin
      rdata_en = 1'b1;
      rdata_d  = c_word;
    end else if (fill_beat && beat == req_addr[OFF_W-1:0]) begin
      rdata_en = 1'b1;
      rdata_d  = fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rdata_en) rdata_q <= rdata_d;
  end

  assign cpu_ready = (state == ST_DONE);
  assign cpu_rdata = rdata_q;
  assign bus_req   = (state == ST_WR_BUS) || (state == ST_FILL_REQ) || (state == ST_FILL);
  assign bus_rd    = (state == ST_FILL_REQ) || (state == ST_FILL);
  assign bus_addr  = bus_rd ? {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : req_addr;
  assign bus_wdata = req_data;
  assign bus_src   = SRC_W'(SELF_ID);
  assign mem_we    = grant_wr;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_data;

  // R4: an ungranted broadcast stays on the bus unchanged
  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_s_q)
    (bus_req && !bus_rd && !bus_gnt) |=>
      (bus_req && !bus_rd && $stable(bus_addr) && $stable(bus_wdata)));

  // R4: memory is written only in the grant cycle of a broadcast
  assert_mem_grant_R4: assert property (@(posedge clk) disable iff (!rst_s_q)
    mem_we |-> (bus_req && bus_gnt && !bus_rd));

  // R3: ready is a single-cycle pulse
  assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_s_q)
    cpu_ready |=> !cpu_ready);
endmodule

// File: tb/wu_snoop_cache_tb.sv
module wu_snoop_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        bus_req, bus_rd, bus_gnt = 1'b0;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [1:0]  bus_src;
  logic        snp_valid = 1'b0;
  logic [11:0] snp_addr = '0;
  logic [31:0] snp_data = '0;
  logic [1:0]  snp_src = '0;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mem [4096];

  always #4 clk = ~clk;

  wu_snoop_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_src(bus_src), .bus_gnt(bus_gnt),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_data(snp_data), .snp_src(snp_src),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // read with a bus model that serves line fetches from the bench memory
  task automatic do_read(input logic [11:0] a, input bit exp_miss,
                         input logic [31:0] exp_d, input string rq);
    bit missed = 1'b0;
    int cyc = 0;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(negedge clk);
    while (!cpu_ready && cyc < 60) begin
      if (bus_req && bus_rd && !missed) begin
        missed = 1'b1;
        chk({rq, " R2 fetch line base"}, {20'h0, bus_addr}, {20'h0, a[11:2], 2'b00});
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        for (int i = 0; i < 4; i++) begin
          fill_valid = 1'b1;
          fill_data  = mem[{a[11:2], 2'(i)}];
          @(negedge clk);
        end
        fill_valid = 1'b0;
        chk({rq, " R2 ready after last beat"}, {31'h0, cpu_ready}, 32'd1);
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!exp_miss) chk({rq, " R3 hit latency"}, cyc, 0);
    chk({rq, " miss/hit"}, {31'h0, missed}, {31'h0, exp_miss});
    chk({rq, " data"}, cpu_rdata, exp_d);
    cpu_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    chk("R4 bus_req", {31'h0, bus_req}, 32'd1);
    chk("R4 bus_rd", {31'h0, bus_rd}, 32'd0);
    chk("R4 bus_src", {30'h0, bus_src}, 32'd1);
    chk("R4 no mem_we before grant", {31'h0, mem_we}, 32'd0);
    @(negedge clk);
    chk("R4 held addr", {20'h0, bus_addr}, {20'h0, a});
    chk("R4 held data", bus_wdata, d);
    chk("R4 stall", {31'h0, cpu_ready}, 32'd0);
    bus_gnt = 1'b1;
    #1;
    chk("R4 mem_we at grant", {31'h0, mem_we}, 32'd1);
    chk("R4 mem_addr", {20'h0, mem_addr}, {20'h0, a});
    chk("R4 mem_wdata", mem_wdata, d);
    @(negedge clk);
    bus_gnt = 1'b0;
    chk("R4 ready after grant", {31'h0, cpu_ready}, 32'd1);
    cpu_req = 1'b0; cpu_we = 1'b0;
    mem[a] = d;
    @(negedge clk);
  endtask

  task automatic do_snoop(input logic [11:0] a, input logic [31:0] d, input logic [1:0] src);
    snp_valid = 1'b1; snp_addr = a; snp_data = d; snp_src = src;
    @(negedge clk);
    snp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ready low", {31'h0, cpu_ready}, 32'd0);
    chk("R1 bus_req low", {31'h0, bus_req}, 32'd0);
    chk("R1 mem_we low", {31'h0, mem_we}, 32'd0);
    do_read(12'h010, 1'b1, mem[12'h010], "R1 first read misses");
  endtask

  task automatic t_fill_offset;
    do_read(12'h0AB, 1'b1, mem[12'h0AB], "R2 miss at offset 3");
    do_read(12'h013, 1'b0, mem[12'h013], "R3 hit");
  endtask

  task automatic t_write_hit;
    do_write(12'h011, 32'h1111_AAAA);
    do_read(12'h011, 1'b0, 32'h1111_AAAA, "R5 write hit read back");
  endtask

  task automatic t_write_miss;
    do_write(12'h200, 32'h2222_BBBB);
    do_read(12'h200, 1'b1, 32'h2222_BBBB, "R6 no allocate on write miss");
  endtask

  task automatic t_snoop_hit;
    do_snoop(12'h012, 32'h3333_CCCC, 2'd2);
    do_read(12'h012, 1'b0, 32'h3333_CCCC, "R7 patched word");
    do_read(12'h013, 1'b0, mem[12'h013], "R7 neighbour word");
  endtask

  task automatic t_snoop_miss;
    do_snoop(12'h344, 32'h4444_0000, 2'd3);
    do_read(12'h344, 1'b1, mem[12'h344], "R8 absent line ignored");
  endtask

  task automatic t_snoop_self;
    do_snoop(12'h010, 32'h5555_0000, 2'd1);
    do_read(12'h010, 1'b0, mem[12'h010], "R9 own broadcast ignored");
  endtask

  task automatic t_conflict;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 12'h011;
    snp_valid = 1'b1; snp_addr = 12'h011; snp_data = 32'h6666_DDDD; snp_src = 2'd3;
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R10 request deferred", {31'h0, cpu_ready}, 32'd0);
    @(negedge clk);
    chk("R10 ready one cycle late", {31'h0, cpu_ready}, 32'd1);
    chk("R10 snoop applied first", cpu_rdata, 32'h6666_DDDD);
    cpu_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'hC0DE_0000 | i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill_offset();
    t_write_hit();
    t_write_miss();
    t_snoop_hit();
    t_snoop_miss();
    t_snoop_self();
    t_conflict();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule